// File: doc/BRIEF.md
# Watermark-Armed Interrupt Mask Controller

This block watches the fill level of a sample buffer and compares it against programmable watermarks. It keeps a word of sticky status flags and drives an active-low interrupt line through an enable mask that software can write but cannot read. One status flag reports the buffer level. The other flags are set by event pulses from neighbouring logic: ready, service and four data flags.

A watermark write carries a mode bit in bit 15 and a payload in the low bits.

- **Low mode** loads the low watermark. The level flag is reported as soon as the count is at or below it.
- **High mode** loads the high watermark and holds back the level flag. The flag stays held until the count has been seen at or above the high watermark. This gives a hysteresis-style arming sequence, so a draining buffer is reported only after it has first filled.

Status flags clear only through a clear strobe that carries a per-bit mask. After reset, only the ready flag is enabled to interrupt.

Top module: `wmirq_top`

## Requirements
- R1: After reset, the status word is 0 and irqN is 1. Only bit 15 (ready) of the enable mask is set, so a ready event pulse alone drives irqN low, while a service event (bit 14) alone leaves irqN high.
- R2: A mask write (wrEn=1, wrSel=0) keeps only bits 15, 14, 8, 6, 2, 1 and 0 of wrData. Status bits outside that set never become 1, and event inputs on those positions are ignored.
- R3: irqN is 0 in the cycle after any cycle in which the status word ANDed with the enable mask is nonzero. It is 1 in the cycle after that AND is zero.
- R4: Status bits are sticky. With clrEn=1, each bit set in clrMask is cleared at the next edge. A set cause in the same cycle as a clear of that bit wins, and the bit stays 1.
- R5: A watermark write (wrEn=1, wrSel=1) with wrData[15]=0 loads the low watermark from wrData[CNT_W-1:0] and drops any withholding. From the edge after the write, the level flag (status bit 8) sets at each edge where sampleCount is at or below the low watermark. This includes the first edge when the count already qualifies.
- R6: The low comparison is inclusive. A count equal to the low watermark sets the level flag, and a count one above it does not.
- R7: A watermark write with wrData[15]=1 loads the high watermark from wrData[CNT_W-1:0] and withholds the level flag. The flag stays withheld until an edge at which sampleCount is at or above the high watermark. From the next edge on, the low condition sets the flag.
- R8: Once the high watermark has been reached, the level flag stays allowed even after the count falls again. The next watermark write clears that state.
- R9: Before the first watermark write after reset, the level flag never sets, whatever the count. The event input at bit 8 has no effect at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 for the enable mask, 1 for a watermark |
| wrData | input | 16 | Write data. For a watermark, bit 15 is the mode and the low CNT_W bits are the payload |
| sampleCount | input | CNT_W | Current buffer sample count |
| evtIn | input | 16 | Event pulses that set the status bits at the same positions |
| clrEn | input | 1 | Status clear strobe |
| clrMask | input | 16 | Status bits to clear when clrEn is 1 |
| statusWord | output | 16 | Sticky status flags |
| irqN | output | 1 | Registered active-low interrupt |

## Verification
The bench builds the block with CNT_W=8, so counts and watermarks span 0 to 255. This keeps the watermark payload well inside bit 15 and leaves the mode bit separate from the count bits. The small width makes it cheap to step the count to exactly one below, equal to and one above each watermark, which covers the inclusive comparisons. It also reaches the high-watermark arming, its persistence after the count falls, and its cancellation by a second write.

// File: rtl/wmirq_pkg.sv
package wmirq_pkg;

  localparam int WORD_W = 16;

  // Status / enable bit positions
  localparam int BIT_READY   = 15;
  localparam int BIT_SERVICE = 14;
  localparam int BIT_LEVEL   = 8;
  localparam int BIT_AUX     = 6;
  localparam int MODE_BIT    = 15;

  // Implemented flag positions; all others read zero
  localparam logic [WORD_W-1:0] FLAG_VALID = 16'hC147;
  localparam logic [WORD_W-1:0] MASK_RESET = 16'h8000;
  localparam logic [WORD_W-1:0] LEVEL_ONLY = 16'h0100;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadMask;
    logic loadLow;
    logic loadHigh;
    logic lowAllowed;
  } ctlStrobe_t;

endpackage

// File: rtl/wmirq_ctrl.sv
module wmirq_ctrl
  import wmirq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic       wrMode,
  input  logic       highCond,
  output ctlStrobe_t strobe
);

  logic armed;     // a watermark write has occurred since reset
  logic gated;     // last watermark write was high mode
  logic highSeen;  // high condition observed since that write
  logic wmWrite;

  assign wmWrite = wrEn & wrSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      gated    <= 1'b0;
      highSeen <= 1'b0;
    end else if (wmWrite) begin
      armed    <= 1'b1;
      gated    <= wrMode;
      highSeen <= 1'b0;
    end else if (armed && gated && highCond) begin
      highSeen <= 1'b1;
    end
  end

  always_comb begin
    strobe.loadMask   = wrEn & ~wrSel;
    strobe.loadLow    = wmWrite & ~wrMode;
    strobe.loadHigh   = wmWrite & wrMode;
    strobe.lowAllowed = armed & (~gated | highSeen);
  end

endmodule

// File: rtl/wmirq_dpath.sv
module wmirq_dpath
  import wmirq_pkg::*;
#(
  parameter int CNT_W = 15   // must not exceed 15: bit 15 is the mode bit
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [CNT_W-1:0]  sampleCount,
  input  logic [WORD_W-1:0] evtIn,
  input  logic              clrEn,
  input  logic [WORD_W-1:0] clrMask,
  output logic              highCond,
  output logic [CNT_W-1:0]  lowWm,
  output logic [WORD_W-1:0] enMask,
  output logic [WORD_W-1:0] statusWord,
  output logic              irqN
);

  localparam logic [WORD_W-1:0] EVT_KEEP = FLAG_VALID & ~LEVEL_ONLY;
  localparam logic [CNT_W-1:0]  WM_HIGH_RST = '1;

  logic [CNT_W-1:0]  highWm;
  logic [CNT_W-1:0]  payload;
  logic              lowCond;
  logic [WORD_W-1:0] setVec;
  logic [WORD_W-1:0] clrVec;

  assign payload = wrData[CNT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowWm  <= '0;
      highWm <= WM_HIGH_RST;
    end else begin
      if (strobe.loadLow)  lowWm  <= payload;
      if (strobe.loadHigh) highWm <= payload;
    end
  end

  assign lowCond  = (sampleCount <= lowWm);
  assign highCond = (sampleCount >= highWm);

  assign setVec = (evtIn & EVT_KEEP)
                | ((strobe.lowAllowed & lowCond) ? LEVEL_ONLY : '0);
  assign clrVec = clrEn ? clrMask : '0;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (FLAG_VALID[i]) begin : g_live
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          statusWord[i] <= 1'b0;
          enMask[i]     <= MASK_RESET[i];
        end else begin
          statusWord[i] <= setVec[i] | (statusWord[i] & ~clrVec[i]);
          if (strobe.loadMask) enMask[i] <= wrData[i];
        end
      end
    end else begin : g_tied
      assign statusWord[i] = 1'b0;
      assign enMask[i]     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqN <= 1'b1;
    else       irqN <= ~|(statusWord & enMask);
  end

endmodule

// File: rtl/wmirq_top.sv
module wmirq_top
  import wmirq_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [15:0]       wrData,
  input  logic [CNT_W-1:0]  sampleCount,
  input  logic [15:0]       evtIn,
  input  logic              clrEn,
  input  logic [15:0]       clrMask,
  output logic [15:0]       statusWord,
  output logic              irqN
);

  ctlStrobe_t       strobe;
  logic             highCond;
  logic [CNT_W-1:0] lowWm;
  logic [15:0]      enMask;

  wmirq_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrMode   (wrData[MODE_BIT]),
    .highCond (highCond),
    .strobe   (strobe)
  );

  wmirq_dpath #(.CNT_W(CNT_W)) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (wrData),
    .sampleCount (sampleCount),
    .evtIn       (evtIn),
    .clrEn       (clrEn),
    .clrMask     (clrMask),
    .highCond    (highCond),
    .lowWm       (lowWm),
    .enMask      (enMask),
    .statusWord  (statusWord),
    .irqN        (irqN)
  );

endmodule

// File: rtl/wmirq_checker.sv
module wmirq_checker
  import wmirq_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic [15:0]       statusWord,
  input logic [15:0]       enMask,
  input logic              irqN,
  input logic              clrEn,
  input logic [CNT_W-1:0]  sampleCount,
  input logic [CNT_W-1:0]  lowWm,
  input logic              lowAllowed
);

  a_r1_reset_mask: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (enMask == MASK_RESET));

  a_r3_irq_assert: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusWord & enMask)) |=> !irqN);

  a_r3_irq_release: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statusWord & enMask)) |=> irqN);

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !clrEn |=> (($past(statusWord) & ~statusWord) == 16'h0000));

  a_r5_level_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[BIT_LEVEL]) |-> $past(lowAllowed && (sampleCount <= lowWm)));

endmodule

bind wmirq_top wmirq_checker #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .statusWord  (statusWord),
  .enMask      (enMask),
  .irqN        (irqN),
  .clrEn       (clrEn),
  .sampleCount (sampleCount),
  .lowWm       (lowWm),
  .lowAllowed  (strobe.lowAllowed)
);

// File: tb/wmirq_top_tb_top.sv
module wmirq_top_tb_top;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic             wrSel = 1'b0;
  logic [15:0]      wrData = '0;
  logic [CNT_W-1:0] sampleCount = 8'd200;
  logic [15:0]      evtIn = '0;
  logic             clrEn = 1'b0;
  logic [15:0]      clrMask = '0;
  logic [15:0]      statusWord;
  logic             irqN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  wmirq_top #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .sampleCount(sampleCount), .evtIn(evtIn), .clrEn(clrEn), .clrMask(clrMask),
    .statusWord(statusWord), .irqN(irqN)
  );

  // {mask, event, expected status}; irq expectation derived from mask & status
  localparam logic [47:0] VEC [7] = '{
    {16'h8000, 16'h8000, 16'h8000},
    {16'h8000, 16'h4000, 16'h4000},
    {16'hFFFF, 16'h0004, 16'h0004},
    {16'h0041, 16'h0040, 16'h0040},
    {16'h0041, 16'h3EB8, 16'h0000},
    {16'h0100, 16'h0100, 16'h0000},
    {16'h0007, 16'h0103, 16'h0003}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrMask(input logic [15:0] v);
    wrEn = 1'b1; wrSel = 1'b0; wrData = v;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic wrWm(input logic [15:0] v);
    wrEn = 1'b1; wrSel = 1'b1; wrData = v;
    tick();
    wrEn = 1'b0; wrSel = 1'b0; wrData = '0;
  endtask

  task automatic clearBits(input logic [15:0] m);
    clrEn = 1'b1; clrMask = m;
    tick();
    clrEn = 1'b0; clrMask = '0;
  endtask

  task automatic pulse(input logic [15:0] e);
    evtIn = e;
    tick();
    evtIn = '0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [15:0] m, e, s;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 status after reset", statusWord, 16'h0000);
    chk("R1 irqN after reset", {15'b0, irqN}, 16'h0001);

    // R3 exact timing with reset mask (R1 ready enabled)
    pulse(16'h8000);
    chk("R3 status set, irq not yet", statusWord, 16'h8000);
    chk("R3 irqN one cycle later still high", {15'b0, irqN}, 16'h0001);
    tick();
    chk("R1 R3 irqN low for ready", {15'b0, irqN}, 16'h0000);
    clearBits(16'h8000);
    chk("R4 ready cleared", statusWord, 16'h0000);
    chk("R3 irqN still low right after clear", {15'b0, irqN}, 16'h0000);
    tick();
    chk("R3 irqN released", {15'b0, irqN}, 16'h0001);

    // R1 service not enabled at reset
    pulse(16'h4000);
    tick();
    chk("R1 service status set", statusWord, 16'h4000);
    chk("R1 service no irq", {15'b0, irqN}, 16'h0001);
    // R4 sticky, then set wins over clear
    repeat (3) tick();
    chk("R4 sticky hold", statusWord, 16'h4000);
    evtIn = 16'h4000; clrEn = 1'b1; clrMask = 16'h4000;
    tick();
    evtIn = '0; clrEn = 1'b0; clrMask = '0;
    chk("R4 set wins over clear", statusWord, 16'h4000);
    clearBits(16'h4000);
    chk("R4 clear alone", statusWord, 16'h0000);

    // Vector table: R2 R3 R9
    for (int i = 0; i < 7; i++) begin
      {m, e, s} = VEC[i];
      wrMask(m);
      clearBits(16'hFFFF);
      pulse(e);
      tick();
      chk($sformatf("R2 R3 R9 vector %0d status", i), statusWord, s);
      chk($sformatf("R2 R3 vector %0d irqN", i), {15'b0, irqN}, {15'b0, ~|(m & s)});
    end

    // Level flag tests, level interrupt enabled
    wrMask(16'h0100);
    clearBits(16'hFFFF);

    // R9 unarmed
    sampleCount = 8'd0;
    repeat (3) tick();
    chk("R9 no level before any watermark write", statusWord, 16'h0000);
    sampleCount = 8'd200;

    // R5 low mode, R6 boundary
    wrWm(16'h000A);
    repeat (2) tick();
    chk("R5 count above low, no flag", statusWord, 16'h0000);
    sampleCount = 8'd11;
    repeat (2) tick();
    chk("R6 one above low, no flag", statusWord, 16'h0000);
    sampleCount = 8'd10;
    tick();
    chk("R6 equal to low sets flag", statusWord, 16'h0100);
    tick();
    chk("R5 level irq", {15'b0, irqN}, 16'h0000);

    // R5 at-once after write
    sampleCount = 8'd200;
    clearBits(16'hFFFF);
    tick();
    chk("R5 cleared with count high", statusWord, 16'h0000);
    sampleCount = 8'd15;
    wrWm(16'h0014);
    chk("R5 write latency, not yet", statusWord, 16'h0000);
    tick();
    chk("R5 immediate after write", statusWord, 16'h0100);

    // R7 high mode withholding
    sampleCount = 8'd200;
    wrEn = 1'b1; wrSel = 1'b1; wrData = 16'h80F0;
    clrEn = 1'b1; clrMask = 16'hFFFF;
    tick();
    wrEn = 1'b0; wrSel = 1'b0; wrData = '0; clrEn = 1'b0; clrMask = '0;
    sampleCount = 8'd5;
    repeat (3) tick();
    chk("R7 withheld below low", statusWord, 16'h0000);
    chk("R7 no irq while withheld", {15'b0, irqN}, 16'h0001);
    sampleCount = 8'd239;
    tick();
    sampleCount = 8'd5;
    repeat (2) tick();
    chk("R7 one below high does not arm", statusWord, 16'h0000);
    sampleCount = 8'd240;
    tick();
    sampleCount = 8'd5;
    tick();
    chk("R7 armed by equal high then low", statusWord, 16'h0100);

    // R8 persistence and cancel
    clearBits(16'h0100);
    chk("R8 high seen persists after fall", statusWord, 16'h0100);
    wrWm(16'h80F0);
    clearBits(16'h0100);
    chk("R8 new high write clears seen", statusWord, 16'h0000);
    repeat (2) tick();
    chk("R8 stays withheld", statusWord, 16'h0000);
    wrWm(16'h0014);
    tick();
    chk("R8 low write drops withholding", statusWord, 16'h0100);

    tick();
    finishRun();
  end

endmodule